// File: doc/BRIEF.md
# Write-Update Line Coherence Controller

This block keeps one cache line coherent under a write-update scheme on a snooping bus. A line is either absent or held in one of four valid states: exclusive clean, shared clean, shared owner (possibly dirty, at most one per system) or modified (dirty, sole copy). No invalid state exists. A filled line stays valid until a later fill replaces it.

On the processor side, each request is already classified as a read or write, hit or miss. Misses fill the line with a bus read. Writes to a shared line broadcast the written word on the bus, so other sharers update their copies and are not invalidated. A write made while other copies exist makes this cache the dirty owner.

On the snoop side, the block supplies the line when another cache reads it and this cache may hold dirty data. It forwards every broadcast word to the data array through a copy-update strobe. The shared "copies exist" wire, sampled in the grant cycle, decides between the exclusive and shared states. The data array, bus arbitration and memory are outside the block.

Top module: `dragon_line_ctrl`

## Requirements
- R1: After reset no line is held, `pr_ready` is 1, `bus_req` is 0 and neither snoop response (`snp_flush`, `upd_we`) is asserted.
- R2: A read miss (`pr_kind`=1) posts exactly one bus read (`bus_cmd`=1). In its grant cycle the line becomes exclusive (`line_state`=0) if `copies_exist` is 0 and shared clean (1) if it is 1. `pr_done` pulses in the cycle after the grant.
- R3: A read hit (`pr_kind`=0) posts no bus transaction, leaves the state unchanged and pulses `pr_done` in the cycle after acceptance.
- R4: A write hit (`pr_kind`=2) on an exclusive or modified line posts no bus transaction, leaves the line modified (3) and pulses `pr_done` in the cycle after acceptance.
- R5: A write hit on a shared clean or shared owner line posts one update (`bus_cmd`=2) carrying the word index and value. In the grant cycle the line becomes shared owner (2) if `copies_exist` is 1 and modified (3) if it is 0.
- R6: A write miss (`pr_kind`=3) first posts a bus read. If `copies_exist` is 0 at that grant, the line becomes modified with no further traffic. Otherwise an update with the written word follows, and its grant applies the rule of R5.
- R7: A snooped bus read moves exclusive to shared clean and modified to shared owner, and leaves the shared states unchanged. `snp_flush` pulses in the cycle after the snoop only when the line was modified or shared owner.
- R8: A snooped update on a shared line pulses `upd_we` in the next cycle with the snooped index and word. A shared owner line then drops to shared clean. A shared clean line stays shared clean.
- R9: While no line is held, snooped reads and updates produce no flush, no copy-update strobe and no state change.
- R10: `pr_ready` is 0 while a bus transaction of this block is pending and in any cycle with `snp_valid` high. A request is taken only when it is 1.
- R11: Once filled, the line stays held; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pr_valid | input | 1 | Processor request valid |
| pr_kind | input | 2 | 0 read hit, 1 read miss, 2 write hit, 3 write miss |
| pr_idx | input | IDX_W | Word index of a write |
| pr_wdata | input | DATA_W | Word value of a write |
| pr_ready | output | 1 | Request can be accepted this cycle |
| pr_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 1 bus read, 2 word update |
| bus_idx | output | IDX_W | Word index carried by an update |
| bus_wdata | output | DATA_W | Word value carried by an update |
| bus_gnt | input | 1 | Pending transaction is on the bus this cycle |
| copies_exist | input | 1 | Wired-OR shared line, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_idx | input | IDX_W | Snooped update word index |
| snp_wdata | input | DATA_W | Snooped update word value |
| snp_flush | output | 1 | Supply the whole line on the bus |
| upd_we | output | 1 | Write the snooped word into the local copy |
| upd_idx | output | IDX_W | Index for the copy update |
| upd_wdata | output | DATA_W | Value for the copy update |
| line_held | output | 1 | A line is present |
| line_state | output | 2 | 0 exclusive, 1 shared clean, 2 shared owner, 3 modified |

## Verification
The embedded properties check, on every cycle, the invariants that do not depend on a scenario. A flush only follows a snoop that found a dirty line. A broadcast never reaches an exclusive or modified copy. The held flag never falls. Exclusive is entered only after a grant with no other copies. A pending update keeps its word stable. Grants and snoops never coincide. The bench scenarios cover the sequence-dependent behaviour: how many transactions each request kind posts and in what order, how the shared wire picks the final state after a one- or two-step write miss, and ownership passing to a writer and being given up by a snooping owner.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

    typedef enum logic [1:0] {
        ST_EXCL  = 2'd0,
        ST_SHCLN = 2'd1,
        ST_SHOWN = 2'd2,
        ST_MOD   = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_UPD  = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        REQ_RD_HIT  = 2'd0,
        REQ_RD_MISS = 2'd1,
        REQ_WR_HIT  = 2'd2,
        REQ_WR_MISS = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_UPD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic     held;
        line_st_e st;
    } line_t;

endpackage

// File: rtl/dragon_req_seq.sv
module dragon_req_seq
    import dragon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pr_valid,
    input  req_kind_e         pr_kind,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [DATA_W-1:0] pr_wdata,
    input  logic              snp_valid,
    input  logic              line_held,
    input  line_st_e          line_st,
    input  logic              bus_gnt,
    input  logic              copies_exist,
    output logic              pr_ready,
    output logic              pr_done,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              ln_we,
    output line_st_e          ln_st
);

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              is_wr;
        logic              done;
    } seq_t;

    seq_t s_q, s_d;
    logic accept;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        ln_we    = 1'b0;
        ln_st    = line_st;
        accept   = (s_q.ph == PH_IDLE) && !snp_valid && pr_valid;
        case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    s_d.idx   = pr_idx;
                    s_d.data  = pr_wdata;
                    s_d.is_wr = (pr_kind == REQ_WR_HIT) || (pr_kind == REQ_WR_MISS);
                    case (pr_kind)
                        REQ_RD_HIT: s_d.done = 1'b1;
                        REQ_WR_HIT: begin
                            if (line_st == ST_EXCL || line_st == ST_MOD) begin
                                ln_we    = 1'b1;
                                ln_st    = ST_MOD;
                                s_d.done = 1'b1;
                            end else begin
                                s_d.ph = PH_UPD;
                            end
                        end
                        default: s_d.ph = PH_FILL;
                    endcase
                end
            end
            PH_FILL: begin
                if (bus_gnt) begin
                    ln_we  = 1'b1;
                    s_d.ph = PH_IDLE;
                    if (!s_q.is_wr) begin
                        ln_st    = copies_exist ? ST_SHCLN : ST_EXCL;
                        s_d.done = 1'b1;
                    end else if (copies_exist) begin
                        ln_st  = ST_SHCLN;
                        s_d.ph = PH_UPD;
                    end else begin
                        ln_st    = ST_MOD;
                        s_d.done = 1'b1;
                    end
                end
            end
            PH_UPD: begin
                if (bus_gnt) begin
                    ln_we    = 1'b1;
                    ln_st    = copies_exist ? ST_SHOWN : ST_MOD;
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pr_ready  = (s_q.ph == PH_IDLE) && !snp_valid;
    assign pr_done   = s_q.done;
    assign bus_req   = (s_q.ph != PH_IDLE);
    assign bus_cmd   = (s_q.ph == PH_FILL) ? BUS_RD :
                       (s_q.ph == PH_UPD)  ? BUS_UPD : BUS_IDLE;
    assign bus_idx   = s_q.idx;
    assign bus_wdata = s_q.data;

    // R10: a grant only arrives for a pending transaction
    p_gnt_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> bus_req);

    // R5: the broadcast word holds still while waiting for the bus
    p_upd_word_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == BUS_UPD && !bus_gnt) |=> ($stable(bus_wdata) && $stable(bus_idx)));

    // R3: hits are only issued against a held line
    p_hit_on_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && pr_ready && (pr_kind == REQ_RD_HIT || pr_kind == REQ_WR_HIT)) |-> line_held);

endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
    import dragon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     snp_valid,
    input  bus_cmd_e snp_cmd,
    input  logic     line_held,
    input  line_st_e line_st,
    output logic     sn_we,
    output line_st_e sn_st,
    output logic     sn_flush,
    output logic     sn_cpy
);

    always_comb begin
        sn_we    = 1'b0;
        sn_st    = line_st;
        sn_flush = 1'b0;
        sn_cpy   = 1'b0;
        if (snp_valid && line_held) begin
            case (snp_cmd)
                BUS_RD: begin
                    case (line_st)
                        ST_EXCL: begin
                            sn_we = 1'b1;
                            sn_st = ST_SHCLN;
                        end
                        ST_MOD: begin
                            sn_we    = 1'b1;
                            sn_st    = ST_SHOWN;
                            sn_flush = 1'b1;
                        end
                        ST_SHOWN: sn_flush = 1'b1;
                        default: ;
                    endcase
                end
                BUS_UPD: begin
                    case (line_st)
                        ST_SHOWN: begin
                            sn_we  = 1'b1;
                            sn_st  = ST_SHCLN;
                            sn_cpy = 1'b1;
                        end
                        ST_SHCLN: sn_cpy = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R8: a broadcast word never reaches a sole copy
    p_upd_not_sole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BUS_UPD && line_held) |-> (line_st == ST_SHCLN || line_st == ST_SHOWN));

endmodule

// File: rtl/dragon_line_ctrl.sv
module dragon_line_ctrl
    import dragon_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int WORDS  = 8,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pr_valid,
    input  logic [1:0]        pr_kind,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [DATA_W-1:0] pr_wdata,
    output logic              pr_ready,
    output logic              pr_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              copies_exist,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [DATA_W-1:0] snp_wdata,
    output logic              snp_flush,
    output logic              upd_we,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [DATA_W-1:0] upd_wdata,
    output logic              line_held,
    output logic [1:0]        line_state
);

    typedef struct packed {
        line_t             line;
        logic              flush;
        logic              cpy_we;
        logic [IDX_W-1:0]  cpy_idx;
        logic [DATA_W-1:0] cpy_data;
    } top_t;

    top_t     t_q, t_d;
    logic     seq_we, sn_we, sn_flush, sn_cpy;
    line_st_e seq_st, sn_st;
    bus_cmd_e seq_cmd;

    dragon_req_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pr_valid     (pr_valid),
        .pr_kind      (req_kind_e'(pr_kind)),
        .pr_idx       (pr_idx),
        .pr_wdata     (pr_wdata),
        .snp_valid    (snp_valid),
        .line_held    (t_q.line.held),
        .line_st      (t_q.line.st),
        .bus_gnt      (bus_gnt),
        .copies_exist (copies_exist),
        .pr_ready     (pr_ready),
        .pr_done      (pr_done),
        .bus_req      (bus_req),
        .bus_cmd      (seq_cmd),
        .bus_idx      (bus_idx),
        .bus_wdata    (bus_wdata),
        .ln_we        (seq_we),
        .ln_st        (seq_st)
    );

    dragon_snoop snoop_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .line_held (t_q.line.held),
        .line_st   (t_q.line.st),
        .sn_we     (sn_we),
        .sn_st     (sn_st),
        .sn_flush  (sn_flush),
        .sn_cpy    (sn_cpy)
    );

    always_comb begin
        t_d        = t_q;
        t_d.cpy_we = 1'b0;
        t_d.flush  = sn_flush;
        if (seq_we) begin
            t_d.line.held = 1'b1;
            t_d.line.st   = seq_st;
        end else if (sn_we) begin
            t_d.line.st   = sn_st;
        end
        if (sn_cpy) begin
            t_d.cpy_we   = 1'b1;
            t_d.cpy_idx  = snp_idx;
            t_d.cpy_data = snp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_cmd    = seq_cmd;
    assign snp_flush  = t_q.flush;
    assign upd_we     = t_q.cpy_we;
    assign upd_idx    = t_q.cpy_idx;
    assign upd_wdata  = t_q.cpy_data;
    assign line_held  = t_q.line.held;
    assign line_state = t_q.line.st;

    // R11: no invalid state, a held line stays held
    p_held_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_held |=> line_held);

    // R7: the line is supplied only after a snooped read found dirty data
    p_flush_from_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> ($past(snp_valid) && $past(snp_cmd) == 2'd1 && $past(line_held)
                       && ($past(line_state) == 2'd3 || $past(line_state) == 2'd2)));

    // R2: exclusive is entered only by a grant that saw no other copies
    p_excl_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_held && line_state == 2'd0 && !($past(line_held) && $past(line_state) == 2'd0))
            |-> ($past(bus_gnt) && !$past(copies_exist)));

    // R10: the bus serialises: own grant and a snoop never share a cycle
    p_gnt_snoop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_gnt && snp_valid));

endmodule

// File: tb/dragon_line_ctrl_tb_top.sv
module dragon_line_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pr_valid = 1'b0;
    logic [1:0]  pr_kind = 2'd0;
    logic [2:0]  pr_idx = 3'd0;
    logic [31:0] pr_wdata = 32'd0;
    logic        pr_ready, pr_done, bus_req;
    logic [1:0]  bus_cmd;
    logic [2:0]  bus_idx;
    logic [31:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic        copies_exist = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = 2'd0;
    logic [2:0]  snp_idx = 3'd0;
    logic [31:0] snp_wdata = 32'd0;
    logic        snp_flush, upd_we, line_held;
    logic [2:0]  upd_idx;
    logic [31:0] upd_wdata;
    logic [1:0]  line_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0]  cmd;
        logic [2:0]  idx;
        logic [31:0] data;
        bit          has_data;
        string       tag;
    } bus_exp_t;

    typedef struct {
        logic        flush;
        logic        cpy;
        logic [2:0]  idx;
        logic [31:0] data;
        string       tag;
    } snp_exp_t;

    bus_exp_t bus_q[$];
    snp_exp_t snp_q[$];
    bit       snp_pend = 1'b0;

    always #5 clk = ~clk;

    dragon_line_ctrl #(.DATA_W(32), .WORDS(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pr_valid(pr_valid), .pr_kind(pr_kind), .pr_idx(pr_idx), .pr_wdata(pr_wdata),
        .pr_ready(pr_ready), .pr_done(pr_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .copies_exist(copies_exist),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx), .snp_wdata(snp_wdata),
        .snp_flush(snp_flush), .upd_we(upd_we), .upd_idx(upd_idx), .upd_wdata(upd_wdata),
        .line_held(line_held), .line_state(line_state)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compares bus traffic and snoop responses against expectations
    always @(negedge clk) begin
        #2;
        if (snp_pend) begin
            snp_pend = 1'b0;
            if (snp_q.size() == 0) begin
                check("snoop response without expectation", 64'd1, 64'd0);
            end else begin
                snp_exp_t e;
                e = snp_q.pop_front();
                check({e.tag, " flush"}, 64'(snp_flush), 64'(e.flush));
                check({e.tag, " copy strobe"}, 64'(upd_we), 64'(e.cpy));
                if (e.cpy) begin
                    check({e.tag, " copy idx"}, 64'(upd_idx), 64'(e.idx));
                    check({e.tag, " copy word"}, 64'(upd_wdata), 64'(e.data));
                end
            end
        end
        if (snp_valid) snp_pend = 1'b1;
        if (bus_req && bus_gnt) begin
            if (bus_q.size() == 0) begin
                check("unexpected bus transaction", 64'(bus_cmd), 64'd0);
            end else begin
                bus_exp_t b;
                b = bus_q.pop_front();
                check({b.tag, " bus cmd"}, 64'(bus_cmd), 64'(b.cmd));
                if (b.has_data) begin
                    check({b.tag, " bus idx"}, 64'(bus_idx), 64'(b.idx));
                    check({b.tag, " bus word"}, 64'(bus_wdata), 64'(b.data));
                end
            end
        end
    end

    task automatic do_proc(input logic [1:0] kind, input logic [2:0] idx, input logic [31:0] d,
                           input logic c0, input logic c1, input logic [1:0] exp_st,
                           input int exp_nbus, input string tag);
        int gi;
        int cyc;
        bus_exp_t b;
        b.idx = idx; b.data = d; b.tag = tag;
        if (kind[0]) begin
            b.cmd = 2'd1; b.has_data = 1'b0; bus_q.push_back(b);
        end
        if ((kind[0] && exp_nbus == 2) || (!kind[0] && exp_nbus == 1)) begin
            b.cmd = 2'd2; b.has_data = 1'b1; bus_q.push_back(b);
        end
        @(negedge clk);
        check({tag, " R10 ready when idle"}, 64'(pr_ready), 64'd1);
        pr_valid = 1'b1; pr_kind = kind; pr_idx = idx; pr_wdata = d;
        @(negedge clk);
        pr_valid = 1'b0;
        gi = 0; cyc = 0;
        while (!pr_done && cyc < 20) begin
            if (bus_req) begin
                check({tag, " R10 not ready while pending"}, 64'(pr_ready), 64'd0);
                bus_gnt = 1'b1;
                copies_exist = (gi == 0) ? c0 : c1;
                gi++;
            end
            @(negedge clk);
            bus_gnt = 1'b0; copies_exist = 1'b0;
            cyc++;
        end
        check({tag, " done pulse"}, 64'(pr_done), 64'd1);
        check({tag, " bus transactions"}, 64'(gi), 64'(exp_nbus));
        check({tag, " line held"}, 64'(line_held), 64'd1);
        check({tag, " state"}, 64'(line_state), 64'(exp_st));
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic [2:0] idx, input logic [31:0] d,
                            input logic exp_flush, input logic exp_cpy, input logic exp_held,
                            input logic [1:0] exp_st, input string tag);
        snp_exp_t e;
        e.flush = exp_flush; e.cpy = exp_cpy; e.idx = idx; e.data = d; e.tag = tag;
        snp_q.push_back(e);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_idx = idx; snp_wdata = d;
        #1;
        check({tag, " R10 not ready during snoop"}, 64'(pr_ready), 64'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        #3;
        check({tag, " held after snoop"}, 64'(line_held), 64'(exp_held));
        if (exp_held) check({tag, " state after snoop"}, 64'(line_state), 64'(exp_st));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 no line", 64'(line_held), 64'd0);
        check("R1 ready", 64'(pr_ready), 64'd1);
        check("R1 no bus req", 64'(bus_req), 64'd0);
        check("R1 no flush", 64'(snp_flush), 64'd0);
        check("R1 no copy strobe", 64'(upd_we), 64'd0);

        do_snoop(2'd1, 3'd0, 32'd0, 1'b0, 1'b0, 1'b0, 2'd0, "R9 read snoop, no line");
        do_snoop(2'd2, 3'd4, 32'h0000_0099, 1'b0, 1'b0, 1'b0, 2'd0, "R9 update snoop, no line");

        do_proc(2'd1, 3'd0, 32'd0, 1'b0, 1'b0, 2'd0, 1, "R2 read miss alone");
        do_proc(2'd0, 3'd0, 32'd0, 1'b0, 1'b0, 2'd0, 0, "R3 read hit exclusive");
        do_proc(2'd2, 3'd1, 32'h0000_1234, 1'b0, 1'b0, 2'd3, 0, "R4 write hit exclusive");
        do_proc(2'd2, 3'd5, 32'h0000_4321, 1'b0, 1'b0, 2'd3, 0, "R4 write hit modified");

        do_snoop(2'd1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b1, 2'd2, "R7 read snoop on modified");
        do_snoop(2'd1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b1, 2'd2, "R7 read snoop on owner");
        do_snoop(2'd2, 3'd2, 32'h0000_00A5, 1'b0, 1'b1, 1'b1, 2'd1, "R8 update snoop on owner");
        do_snoop(2'd1, 3'd0, 32'd0, 1'b0, 1'b0, 1'b1, 2'd1, "R7 read snoop on shared clean");
        do_snoop(2'd2, 3'd3, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 2'd1, "R8 update snoop on shared clean");

        do_proc(2'd0, 3'd0, 32'd0, 1'b0, 1'b0, 2'd1, 0, "R3 read hit shared clean");
        do_proc(2'd2, 3'd0, 32'h0000_0011, 1'b1, 1'b0, 2'd2, 1, "R5 write hit shared, copies");
        do_proc(2'd2, 3'd3, 32'h0000_0022, 1'b0, 1'b0, 2'd3, 1, "R5 write hit owner, no copies");

        do_proc(2'd1, 3'd0, 32'd0, 1'b1, 1'b0, 2'd1, 1, "R2 read miss shared");
        check("R11 line still held", 64'(line_held), 64'd1);
        do_proc(2'd3, 3'd6, 32'h0000_0066, 1'b1, 1'b1, 2'd2, 2, "R6 write miss, copies stay");
        do_proc(2'd3, 3'd7, 32'h0000_0077, 1'b0, 1'b0, 2'd3, 1, "R6 write miss alone");
        do_proc(2'd3, 3'd2, 32'h0000_0088, 1'b1, 1'b0, 2'd3, 2, "R6 write miss, copies vanish");

        do_proc(2'd1, 3'd0, 32'd0, 1'b0, 1'b0, 2'd0, 1, "R2 refill exclusive");
        do_snoop(2'd1, 3'd0, 32'd0, 1'b0, 1'b0, 1'b1, 2'd1, "R7 read snoop on exclusive");
        check("R11 held after snoops", 64'(line_held), 64'd1);

        repeat (3) @(negedge clk);
        check("bus expectations drained", 64'(bus_q.size()), 64'd0);
        check("snoop expectations drained", 64'(snp_q.size()), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule